// File: doc/BRIEF.md
# Wakeup-Disable Counter and Wakeup Dispatcher

This block decides when pending wakeups may interrupt the running process, and it delivers each taken wakeup to a condition variable. It keeps a nesting counter of wakeup-disable requests and a 16-bit pending word. Bits 0 to 14 of that word are per-channel request flags, and bit 15 is a "disabled" flag that is set whenever the counter is non-zero. Because of this encoding, a single signed "greater than zero" test on the word means both "enabled" and "something pending".

When a wakeup is taken, the block snapshots the pending channels and clears them from the word. If the timer channel is among them, it first asks an external engine for a timeout scan. It then walks the channels upward from bit 0. For each channel it reads a pointer from a table in memory. A NIL pointer drops the wakeup. Otherwise the block reads the condition-variable word. If that variable's queue is empty, the block marks a wakeup as waiting in it. If not, it hands the variable to an external queue engine to wake the head waiter, and waits for that engine to acknowledge. At the end of the dispatch it may raise a one-cycle reschedule request.

Top module: `wakeupDispatch`

## Requirements
- R1: An increment command raises the disable counter by one, saturating at its maximum, and always sets bit 15 of the pending word. While bit 15 is set, no dispatch starts.
- R2: A decrement command lowers a non-zero counter by one, and clears bit 15 only when the counter reaches zero. A decrement at zero changes nothing. When increment and decrement arrive in the same cycle, only the increment acts.
- R3: A dispatch starts only when the block is idle, the pending word read as a signed 16-bit value is greater than zero, and no increment arrives in that cycle.
- R4: After a decrement brings the counter to zero, no dispatch starts until an instruction-step pulse has been seen.
- R5: At the start of a dispatch, all serviced channel bits are cleared from the pending word. Channel requests that arrive during a dispatch are ORed into the word and are serviced by the next dispatch.
- R6: When channel 4 (the timer channel) is serviced, `timerScanReq` is held until `timerScanAck` arrives, and this happens before any memory access of that dispatch.
- R7: Serviced channels are handled in ascending order. Channel k first reads the table word at address `TBL_BASE + k` (default 32).
- R8: A table entry of zero (NIL) discards that channel: no condition-variable access and no wake request follow for it.
- R9: If bits 14:0 of the condition-variable word are zero, the word is written back with bit 15 set. Otherwise `wakeReq` is raised with `wakeCvPtr` equal to the pointer, and both are held until `wakeAck` arrives.
- R10: At the end of a dispatch, `reschedReq` pulses for one cycle if `fromIdle` was high when the dispatch started, or if a wake was acknowledged, or if the timer scan acknowledged with `scanMoved` high. Otherwise it stays low.
- R11: Memory reads return data on `memRdata` in the cycle after `memReq`. At most one of `memReq`, `wakeReq` and `timerScanReq` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chanReq | input | 15 | Per-channel wakeup request pulses |
| incCmd | input | 1 | Increment the disable counter |
| decCmd | input | 1 | Decrement the disable counter |
| instrStep | input | 1 | One instruction slot has completed |
| fromIdle | input | 1 | Processor is in the idle loop (sampled at dispatch start) |
| memReq | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 16 | Memory word address |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, valid the cycle after a read |
| wakeReq | output | 1 | Request to wake the head waiter of a condition variable |
| wakeCvPtr | output | 16 | Condition-variable pointer for the wake request |
| wakeAck | input | 1 | Wake request completed |
| timerScanReq | output | 1 | Request for a timeout scan |
| timerScanAck | input | 1 | Timeout scan completed |
| scanMoved | input | 1 | With the scan acknowledge: the scan moved a process |
| reschedReq | output | 1 | One-cycle reschedule request at the end of a dispatch |

## Verification
A counter or disable-flag error shows up at the ports as a dispatch that starts too early or never starts, which is visible as memory traffic appearing or missing within a few cycles of the channel pulse. A wrong snapshot of the serviced bits, or a wrong channel index, shows as wake requests in the wrong order, accesses to the wrong table or variable addresses, or a channel that is serviced twice or not at all. A wrong "moved" or idle flag shows only at the end of the dispatch, as a missing or extra reschedule pulse. For this reason every run compares the complete wake log, the condition-variable memory image and the count of reschedule pulses against an independent model.

// File: rtl/wakeupDispatchPkg.sv
package wakeupDispatchPkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TIMER,
    S_PICK,
    S_RDPTR,
    S_WTPTR,
    S_RDCV,
    S_WTCV,
    S_WRCV,
    S_WAKE,
    S_DONE
  } dispState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic take;       // snapshot pending channels, start a dispatch
    logic pickIdx;    // load channel index from the lowest serviced bit
    logic latchPtr;   // capture table pointer, retire channel bit
    logic latchCv;    // capture condition-variable word
    logic markMoved;  // a process was moved during this dispatch
    logic selTable;   // memory address selects the pointer table
    logic finish;     // last cycle of the dispatch
  } ctlStrobe_t;

  // Conditions reported by the datapath to the control FSM.
  typedef struct packed {
    logic canTake;
    logic timerHit;
    logic svcEmpty;
    logic ptrNil;
    logic cvEmpty;
  } dpStatus_t;

endpackage

// File: rtl/wakeupDispatchDatapath.sv
module wakeupDispatchDatapath
  import wakeupDispatchPkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int CNT_W      = 4,
  parameter int TBL_BASE   = 32,
  parameter int TIMER_CHAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-2:0] chanReq,
  input  logic              incCmd,
  input  logic              decCmd,
  input  logic              instrStep,
  input  logic              fromIdle,
  input  ctlStrobe_t        st,
  input  logic [WORD_W-1:0] memRdata,
  output dpStatus_t         status,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [WORD_W-1:0] cvPtr,
  output logic              reschedReq,
  output logic [CNT_W-1:0]  cntOut,
  output logic [WORD_W-1:0] pendOut
);

  localparam int NUM_CHAN = WORD_W - 1;
  localparam int IDX_W    = $clog2(NUM_CHAN);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [WORD_W-1:0] WAIT_BIT = WORD_W'(1) << (WORD_W - 1);

  logic [CNT_W-1:0]    cnt, cntNext;
  logic [WORD_W-1:0]   pend;
  logic                flagNext;
  logic [NUM_CHAN-1:0] pendLowNext;
  logic                guard, guardNext;
  logic [NUM_CHAN-1:0] svc;
  logic [IDX_W-1:0]    idx, lowIdx;
  logic [WORD_W-1:0]   ptr, cvWord;
  logic                moved, idleLatched;

  // Disable counter and the sign flag of the pending word.
  always_comb begin
    cntNext   = cnt;
    flagNext  = pend[WORD_W-1];
    guardNext = guard;
    if (instrStep) guardNext = 1'b0;
    if (incCmd) begin
      if (cnt != CNT_MAX) cntNext = cnt + CNT_ONE;
      flagNext = 1'b1;
    end else if (decCmd && (cnt != '0)) begin
      cntNext = cnt - CNT_ONE;
      if (cnt == CNT_ONE) begin
        flagNext  = 1'b0;
        guardNext = 1'b1;
      end
    end
  end

  // Serviced bits leave the word at the take; new requests always merge.
  always_comb begin
    pendLowNext = pend[NUM_CHAN-1:0];
    if (st.take) pendLowNext = '0;
    pendLowNext = pendLowNext | chanReq;
  end

  // Lowest serviced channel.
  always_comb begin
    lowIdx = '0;
    for (int i = NUM_CHAN - 1; i >= 0; i--) begin
      if (svc[i]) lowIdx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= '0;
      pend        <= '0;
      guard       <= 1'b0;
      svc         <= '0;
      idx         <= '0;
      ptr         <= '0;
      cvWord      <= '0;
      moved       <= 1'b0;
      idleLatched <= 1'b0;
    end else begin
      cnt                  <= cntNext;
      guard                <= guardNext;
      pend[WORD_W-1]       <= flagNext;
      pend[NUM_CHAN-1:0]   <= pendLowNext;
      if (st.take) begin
        svc         <= pend[NUM_CHAN-1:0];
        moved       <= 1'b0;
        idleLatched <= fromIdle;
      end
      if (st.pickIdx) idx <= lowIdx;
      if (st.latchPtr) begin
        svc[idx] <= 1'b0;
        ptr      <= memRdata;
      end
      if (st.latchCv) cvWord <= memRdata;
      if (st.markMoved) moved <= 1'b1;
    end
  end

  assign status.canTake  = !pend[WORD_W-1] && (|pend[NUM_CHAN-1:0]) && !guard && !incCmd;
  assign status.timerHit = svc[TIMER_CHAN];
  assign status.svcEmpty = (svc == '0);
  assign status.ptrNil   = (memRdata == '0);
  assign status.cvEmpty  = (memRdata[WORD_W-2:0] == '0);

  assign memAddr    = st.selTable ? (WORD_W'(TBL_BASE) + WORD_W'(idx)) : ptr;
  assign memWdata   = cvWord | WAIT_BIT;
  assign cvPtr      = ptr;
  assign reschedReq = st.finish && (idleLatched || moved);
  assign cntOut     = cnt;
  assign pendOut    = pend;

endmodule

// File: rtl/wakeupDispatchControl.sv
module wakeupDispatchControl
  import wakeupDispatchPkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  dpStatus_t  status,
  input  logic       wakeAck,
  input  logic       timerScanAck,
  input  logic       scanMoved,
  output ctlStrobe_t st,
  output logic       memReq,
  output logic       memWe,
  output logic       wakeReq,
  output logic       timerScanReq,
  output logic       busy
);

  dispState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext    = state;
    st           = '0;
    memReq       = 1'b0;
    memWe        = 1'b0;
    wakeReq      = 1'b0;
    timerScanReq = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (status.canTake) begin
          st.take   = 1'b1;
          stateNext = S_TIMER;
        end
      end
      S_TIMER: begin
        // Timer channel first; otherwise straight to channel walk.
        if (!status.timerHit) begin
          stateNext = S_PICK;
        end else begin
          timerScanReq = 1'b1;
          if (timerScanAck) begin
            st.markMoved = scanMoved;
            stateNext    = S_PICK;
          end
        end
      end
      S_PICK: begin
        if (status.svcEmpty) begin
          stateNext = S_DONE;
        end else begin
          st.pickIdx = 1'b1;
          stateNext  = S_RDPTR;
        end
      end
      S_RDPTR: begin
        memReq      = 1'b1;
        st.selTable = 1'b1;
        stateNext   = S_WTPTR;
      end
      S_WTPTR: begin
        st.latchPtr = 1'b1;
        stateNext   = status.ptrNil ? S_PICK : S_RDCV;
      end
      S_RDCV: begin
        memReq    = 1'b1;
        stateNext = S_WTCV;
      end
      S_WTCV: begin
        st.latchCv = 1'b1;
        stateNext  = status.cvEmpty ? S_WRCV : S_WAKE;
      end
      S_WRCV: begin
        memReq    = 1'b1;
        memWe     = 1'b1;
        stateNext = S_PICK;
      end
      S_WAKE: begin
        wakeReq = 1'b1;
        if (wakeAck) begin
          st.markMoved = 1'b1;
          stateNext    = S_PICK;
        end
      end
      S_DONE: begin
        st.finish = 1'b1;
        stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/wakeupDispatch.sv
module wakeupDispatch
  import wakeupDispatchPkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int CNT_W      = 4,
  parameter int TBL_BASE   = 32,
  parameter int TIMER_CHAN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-2:0] chanReq,
  input  logic              incCmd,
  input  logic              decCmd,
  input  logic              instrStep,
  input  logic              fromIdle,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              wakeReq,
  output logic [WORD_W-1:0] wakeCvPtr,
  input  logic              wakeAck,
  output logic              timerScanReq,
  input  logic              timerScanAck,
  input  logic              scanMoved,
  output logic              reschedReq
);

  ctlStrobe_t        st;
  dpStatus_t         status;
  logic              busy;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] pend;

  wakeupDispatchControl u_ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .status       (status),
    .wakeAck      (wakeAck),
    .timerScanAck (timerScanAck),
    .scanMoved    (scanMoved),
    .st           (st),
    .memReq       (memReq),
    .memWe        (memWe),
    .wakeReq      (wakeReq),
    .timerScanReq (timerScanReq),
    .busy         (busy)
  );

  wakeupDispatchDatapath #(
    .WORD_W     (WORD_W),
    .CNT_W      (CNT_W),
    .TBL_BASE   (TBL_BASE),
    .TIMER_CHAN (TIMER_CHAN)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .chanReq    (chanReq),
    .incCmd     (incCmd),
    .decCmd     (decCmd),
    .instrStep  (instrStep),
    .fromIdle   (fromIdle),
    .st         (st),
    .memRdata   (memRdata),
    .status     (status),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .cvPtr      (wakeCvPtr),
    .reschedReq (reschedReq),
    .cntOut     (cnt),
    .pendOut    (pend)
  );

endmodule

// File: rtl/wakeupDispatchChecker.sv
module wakeupDispatchChecker #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              decCmd,
  input logic              incCmd,
  input logic [CNT_W-1:0]  cnt,
  input logic [WORD_W-1:0] pend,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic [WORD_W-1:0] memWdata,
  input logic              wakeReq,
  input logic              wakeAck,
  input logic [WORD_W-1:0] wakeCvPtr,
  input logic              timerScanReq,
  input logic              reschedReq
);

  assert_inc_disables_R1: assert property (@(posedge clk) disable iff (!rst_n)
    incCmd |=> pend[WORD_W-1]);

  assert_flag_tracks_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pend[WORD_W-1] == (cnt != '0));

  assert_take_when_positive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!pend[WORD_W-1] && (pend[WORD_W-2:0] != '0) && !incCmd));

  assert_no_take_after_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(decCmd));

  assert_write_sets_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && memWe) |-> memWdata[WORD_W-1]);

  assert_wake_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wakeReq && !wakeAck) |=> (wakeReq && $stable(wakeCvPtr)));

  assert_resched_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reschedReq |=> !busy);

  assert_one_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({memReq, wakeReq, timerScanReq}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(memReq || wakeReq || timerScanReq || reschedReq));

endmodule

bind wakeupDispatch wakeupDispatchChecker #(
  .WORD_W (WORD_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .decCmd       (decCmd),
  .incCmd       (incCmd),
  .cnt          (cnt),
  .pend         (pend),
  .busy         (busy),
  .memReq       (memReq),
  .memWe        (memWe),
  .memWdata     (memWdata),
  .wakeReq      (wakeReq),
  .wakeAck      (wakeAck),
  .wakeCvPtr    (wakeCvPtr),
  .timerScanReq (timerScanReq),
  .reschedReq   (reschedReq)
);

// File: tb/tb_wakeupDispatch.sv
`timescale 1ns/1ps
module tb_wakeupDispatch;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [14:0] chanReq = '0;
  logic incCmd = 1'b0, decCmd = 1'b0, instrStep = 1'b0, fromIdle = 1'b0;
  logic memReq, memWe;
  logic [15:0] memAddr, memWdata;
  logic [15:0] memRdata = '0;
  logic wakeReq;
  logic [15:0] wakeCvPtr;
  logic wakeAck = 1'b0;
  logic timerScanReq;
  logic timerScanAck = 1'b0;
  logic scanMoved = 1'b0;
  logic reschedReq;

  wakeupDispatch dut (
    .clk(clk), .rst_n(rst_n), .chanReq(chanReq), .incCmd(incCmd), .decCmd(decCmd),
    .instrStep(instrStep), .fromIdle(fromIdle), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .wakeReq(wakeReq),
    .wakeCvPtr(wakeCvPtr), .wakeAck(wakeAck), .timerScanReq(timerScanReq),
    .timerScanAck(timerScanAck), .scanMoved(scanMoved), .reschedReq(reschedReq)
  );

  logic [15:0] mem    [0:255];
  logic [15:0] expMem [0:255];
  logic [15:0] wakeLog [0:1023];
  logic [15:0] expLog  [0:1023];

  int wakeCnt = 0, reschedCnt = 0, timerCnt = 0, memAccCnt = 0, memAtTimer = 0;
  int wakeDly = 0, timerDly = 0;
  int errs = 0, checks = 0;
  int baseWake, baseResched, baseTimer, baseMem;
  int expWakeCnt, expResched, expTimer;
  bit finished = 0;

  // Memory, wake engine and scan engine, all on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (memReq) begin
        memAccCnt++;
        if (memWe) mem[memAddr[7:0]] = memWdata;
        else       memRdata = mem[memAddr[7:0]];
      end
      if (wakeAck) wakeAck = 1'b0;
      else if (wakeReq) begin
        if (wakeDly == 2) begin
          wakeAck = 1'b1;
          wakeLog[wakeCnt % 1024] = wakeCvPtr;
          wakeCnt++;
          wakeDly = 0;
        end else wakeDly++;
      end
      if (timerScanAck) timerScanAck = 1'b0;
      else if (timerScanReq) begin
        if (timerDly == 0) memAtTimer = memAccCnt;
        if (timerDly == 2) begin
          timerScanAck = 1'b1;
          timerCnt++;
          timerDly = 0;
        end else timerDly++;
      end
      if (reschedReq) reschedCnt++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic startRun();
    baseWake = wakeCnt; baseResched = reschedCnt; baseTimer = timerCnt; baseMem = memAccCnt;
    expWakeCnt = 0; expResched = 0; expTimer = 0;
    for (int a = 0; a < 256; a++) expMem[a] = mem[a];
  endtask

  // Independent model of one dispatch over the serviced mask.
  task automatic predict(input logic [14:0] mask, input bit idle, input bit sm);
    bit mv;
    mv = mask[4] && sm;
    if (mask[4]) expTimer++;
    for (int k = 0; k < 15; k++) begin
      if (mask[k]) begin
        logic [15:0] p;
        p = expMem[32 + k];
        if (p != 16'd0) begin
          if (expMem[p[7:0]][14:0] == 15'd0) expMem[p[7:0]][15] = 1'b1;
          else begin
            expLog[(baseWake + expWakeCnt) % 1024] = p;
            expWakeCnt++;
            mv = 1'b1;
          end
        end
      end
    end
    if (idle || mv) expResched++;
  endtask

  task automatic compareRun(input string tag);
    int n;
    n = wakeCnt - baseWake;
    check(n == expWakeCnt, {tag, " wake count"}, n, expWakeCnt);
    for (int i = 0; i < n && i < expWakeCnt; i++)
      check(wakeLog[(baseWake + i) % 1024] == expLog[(baseWake + i) % 1024], {tag, " wake order"},
            int'(wakeLog[(baseWake + i) % 1024]), int'(expLog[(baseWake + i) % 1024]));
    for (int a = 64; a < 128; a++)
      if (mem[a] != expMem[a]) check(0, {tag, " cv word"}, int'(mem[a]), int'(expMem[a]));
    check(1, {tag, " cv image"}, 0, 0);
    check(reschedCnt - baseResched == expResched, {tag, " resched"}, reschedCnt - baseResched, expResched);
    check(timerCnt - baseTimer == expTimer, {tag, " timer scan"}, timerCnt - baseTimer, expTimer);
  endtask

  task automatic pulse(input logic [14:0] mask);
    @(negedge clk) chanReq = mask;
    @(negedge clk) chanReq = '0;
  endtask

  task automatic cmd(input bit inc, input bit dec, input bit step);
    @(negedge clk) begin incCmd = inc; decCmd = dec; instrStep = step; end
    @(negedge clk) begin incCmd = 0; decCmd = 0; instrStep = 0; end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run(input string tag, input logic [14:0] mask, input bit idle, input bit sm);
    fromIdle = idle; scanMoved = sm;
    startRun();
    predict(mask, idle, sm);
    pulse(mask);
    settle(300);
    compareRun(tag);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    for (int a = 0; a < 256; a++) mem[a] = '0;
    // Table: ch k -> 64+4k; default CVs alternate empty / non-empty.
    for (int k = 0; k < 15; k++) begin
      mem[32 + k] = 16'(64 + 4 * k);
      mem[64 + 4 * k] = (k % 2 == 0) ? 16'h0000 : 16'(100 + k);
    end
    mem[32 + 3] = 16'd0;

    settle(3);
    rst_n = 1'b1;
    settle(5);
    // Reset state
    check(memReq == 0 && wakeReq == 0 && timerScanReq == 0, "reset outputs quiet R11", int'(memReq), 0);
    check(reschedCnt == 0, "reset no resched R10", reschedCnt, 0);

    // R1: disabled after increment
    cmd(1, 0, 0);
    startRun();
    pulse(15'h0002);
    settle(40);
    check(memAccCnt == baseMem, "R1 no dispatch while disabled", memAccCnt - baseMem, 0);
    // R4: decrement to zero, no step yet
    cmd(0, 1, 0);
    settle(40);
    check(memAccCnt == baseMem, "R4 no dispatch before step", memAccCnt - baseMem, 0);
    fromIdle = 0; scanMoved = 0;
    predict(15'h0002, 0, 0);
    cmd(0, 0, 1);
    settle(300);
    compareRun("R4 dispatch after step");

    // R2: nested increments, one decrement keeps disabled
    cmd(1, 0, 0); cmd(1, 0, 0); cmd(0, 1, 0);
    startRun();
    pulse(15'h0004);
    settle(40);
    check(memAccCnt == baseMem, "R2 still disabled at count 1", memAccCnt - baseMem, 0);
    predict(15'h0004, 0, 0);
    cmd(0, 1, 0); cmd(0, 0, 1);
    settle(300);
    compareRun("R2 nested release");
    // R2: decrement at zero ignored (no guard raised)
    cmd(0, 1, 0);
    run("R2 dec at zero ignored", 15'h0020, 0, 0);
    // R2: inc and dec together -> inc wins
    cmd(1, 1, 0);
    startRun();
    pulse(15'h0040);
    settle(40);
    check(memAccCnt == baseMem, "R2 inc wins over dec", memAccCnt - baseMem, 0);
    predict(15'h0040, 0, 0);
    cmd(0, 1, 0); cmd(0, 0, 1);
    settle(300);
    compareRun("R2 inc wins release");

    // R7 R8 R9 R10: mixed NIL, empty, non-empty, normal execution
    run("R7 R8 R9 mixed order", 15'h02AA, 0, 0);
    run("R10 only empty cv no resched", 15'h0101, 0, 0);
    run("R8 R10 nil only from idle", 15'h0008, 1, 0);
    run("R8 nil only normal", 15'h0008, 0, 0);

    // R6: timer channel first
    startRun();
    fromIdle = 0; scanMoved = 1;
    predict(15'h0111, 0, 1);
    pulse(15'h0111);
    settle(300);
    compareRun("R6 timer");
    check(memAtTimer == baseMem, "R6 scan before memory", memAtTimer - baseMem, 0);
    run("R6 R10 timer moved nothing", 15'h0010, 0, 0);

    // R5: request arriving mid-dispatch serviced by next take
    fromIdle = 0; scanMoved = 0;
    startRun();
    predict(15'h0002, 0, 0);
    predict(15'h0800, 0, 0);
    pulse(15'h0002);
    settle(6);
    pulse(15'h0800);
    settle(400);
    compareRun("R5 late request");

    // Random runs
    for (int it = 0; it < 20; it++) begin
      logic [14:0] m;
      for (int k = 0; k < 15; k++) begin
        int r;
        r = $urandom_range(0, 9);
        mem[32 + k] = (r < 3) ? 16'd0 : 16'(64 + 4 * k);
        r = $urandom_range(0, 2);
        mem[64 + 4 * k] = (r == 0) ? 16'h0000 : (r == 1) ? 16'h8000 : 16'($urandom_range(1, 32767));
      end
      m = 15'($urandom_range(1, 32767));
      run("R3 R7 R9 R10 random", m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule